// File: doc/BRIEF.md
# Register Window Occupancy Controller

This block keeps the bookkeeping counters of a windowed register file: how many windows may still be saved, how many may be restored, how many belong to another context, and how many are known to be clean. It also holds a six-bit spill configuration word. A single command strobe with a two-bit opcode drives three operations. A spill-done command records that one window was written out to memory. A fill-done command records that one window was read back. A flush-all command asks whether any window is still occupied; if one is, it raises a spill trap whose vector offset comes from one of two three-bit fields of the configuration word.

Spill-done and fill-done first consume from the other-context counter. They fall back to the restore or save counter only when the other-context counter is zero. The clean counter saturates one below the window count. A command whose precondition does not hold changes no counter and raises an error pulse instead. Any single counter, or the configuration word, can also be loaded directly through a write port. The window count `NWIN` is a parameter, and each counter is `$clog2(NWIN)` bits wide.

A three-state machine drives the pulsed outputs. ST_IDLE is the quiet state. ST_TRAP presents a trap for one cycle. ST_FAULT presents a precondition error for one cycle. The transitions are the same from every state. A flush-all that finds an occupied window goes to ST_TRAP. A spill-done or fill-done that fails its precondition goes to ST_FAULT. Any other cycle returns to ST_IDLE.

Top module: `rwo_ctrl`

## Requirements
- R1: After reset, save_room equals NWIN-2, restore_room, foreign_cnt, clean_cnt and spill_cfg are zero, and trap_valid and assert_err are low.
- R2: A spill-done command (cmd_op 2'b00) whose precondition holds increments save_room. It then decrements foreign_cnt if foreign_cnt is nonzero; otherwise it decrements restore_room. The precondition is save_room < NWIN-2 and (foreign_cnt != 0 or restore_room != 0).
- R3: A fill-done command (cmd_op 2'b01) whose precondition holds increments restore_room. It then decrements foreign_cnt if foreign_cnt is nonzero; otherwise it decrements save_room. The precondition is restore_room < NWIN-2 and (save_room != 0 or foreign_cnt != 0).
- R4: A successful fill-done increments clean_cnt only while clean_cnt < NWIN-1; otherwise clean_cnt holds.
- R5: A spill-done or fill-done whose precondition fails leaves every counter unchanged, and assert_err is high for the one cycle after the command.
- R6: A flush-all command (cmd_op 2'b10) raises trap_valid in the cycle after the command exactly when save_room != NWIN-2. It never changes a counter.
- R7: On a flush-all trap, trap_other is 1 and trap_offset is 4*spill_cfg[5:3] when foreign_cnt is nonzero. Otherwise trap_other is 0 and trap_offset is 4*spill_cfg[2:0]. Both are sampled from the values before the command's edge.
- R8: With wr_en high, wr_sel selects the target: 0 save_room, 1 restore_room, 2 foreign_cnt, 3 clean_cnt, 4 spill_cfg. The target takes the low bits of wr_data on the next edge. Selects 5 to 7 change nothing.
- R9: When a direct write and a command fall in the same cycle, the command is evaluated on the values before the edge. The written target then takes wr_data, and every other counter takes the command's result.
- R10: trap_valid and assert_err are each high for one cycle per triggering command, and they are never high together.
- R11: The reserved opcode 2'b11 changes no counter and raises neither pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Opcode: 00 spill-done, 01 fill-done, 10 flush-all, 11 reserved |
| wr_en | input | 1 | Direct write enable |
| wr_sel | input | 3 | Direct write target select |
| wr_data | input | max(CW,6) | Direct write value |
| save_room | output | CW | Windows that may still be saved |
| restore_room | output | CW | Windows that may be restored |
| foreign_cnt | output | CW | Windows owned by another context |
| clean_cnt | output | CW | Clean windows available |
| spill_cfg | output | 6 | Spill vector configuration word |
| trap_valid | output | 1 | One-cycle spill trap pulse |
| trap_other | output | 1 | Trap kind: 1 other-context spill, 0 normal spill |
| trap_offset | output | 5 | Trap vector offset |
| assert_err | output | 1 | One-cycle precondition failure pulse |

## Verification
A direct write and a command can land in the same cycle, and the write may hit the very counter that the command reads or updates. The bench drives this collision in directed cases, for example a write to save_room issued together with a spill-done. It also arises in the random phase, where writes with arbitrary targets overlap commands of every opcode. The bench model judges each such cycle in two steps. It applies the command to the values from before the edge, and it then overwrites only the written target. Every counter, both pulses and the trap vector are compared against that model.

// File: rtl/rwo_pkg.sv
package rwo_pkg;

    localparam int CFG_W   = 6;
    localparam int FIELD_W = 3;
    localparam int OFS_W   = FIELD_W + 2;

    localparam logic [1:0] OP_SPILL_DONE = 2'b00;
    localparam logic [1:0] OP_FILL_DONE  = 2'b01;
    localparam logic [1:0] OP_FLUSH_ALL  = 2'b10;

    localparam logic [2:0] SEL_SAVE    = 3'd0;
    localparam logic [2:0] SEL_RESTORE = 3'd1;
    localparam logic [2:0] SEL_FOREIGN = 3'd2;
    localparam logic [2:0] SEL_CLEAN   = 3'd3;
    localparam logic [2:0] SEL_CFG     = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRAP  = 2'd1,
        ST_FAULT = 2'd2
    } rwo_state_e;

endpackage

// File: rtl/rwo_update.sv
module rwo_update #(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN)
) (
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [CW-1:0] save_q,
    input  logic [CW-1:0] restore_q,
    input  logic [CW-1:0] foreign_q,
    input  logic [CW-1:0] clean_q,
    output logic [CW-1:0] save_n,
    output logic [CW-1:0] restore_n,
    output logic [CW-1:0] foreign_n,
    output logic [CW-1:0] clean_n,
    output logic          fail
);
    import rwo_pkg::*;

    localparam logic [CW-1:0] LIM       = CW'(NWIN - 2);
    localparam logic [CW-1:0] CLEAN_MAX = CW'(NWIN - 1);
    localparam logic [CW-1:0] ONE       = CW'(1);

    logic spill_ok;
    logic fill_ok;

    assign spill_ok = (save_q < LIM) && ((foreign_q != '0) || (restore_q != '0));
    assign fill_ok  = (restore_q < LIM) && ((save_q != '0) || (foreign_q != '0));

    always_comb begin
        save_n    = save_q;
        restore_n = restore_q;
        foreign_n = foreign_q;
        clean_n   = clean_q;
        fail      = 1'b0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_SPILL_DONE: begin
                    if (spill_ok) begin
                        save_n = save_q + ONE;
                        if (foreign_q != '0) foreign_n = foreign_q - ONE;
                        else                 restore_n = restore_q - ONE;
                    end else begin
                        fail = 1'b1;
                    end
                end
                OP_FILL_DONE: begin
                    if (fill_ok) begin
                        restore_n = restore_q + ONE;
                        if (foreign_q != '0) foreign_n = foreign_q - ONE;
                        else                 save_n    = save_q - ONE;
                        if (clean_q < CLEAN_MAX) clean_n = clean_q + ONE;
                    end else begin
                        fail = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rwo_flush.sv
module rwo_flush #(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN)
) (
    input  logic [CW-1:0]              save_q,
    input  logic [CW-1:0]              foreign_q,
    input  logic [rwo_pkg::CFG_W-1:0]  cfg_q,
    output logic                       need,
    output logic                       is_other,
    output logic [rwo_pkg::OFS_W-1:0]  offset
);
    import rwo_pkg::*;

    localparam logic [CW-1:0] LIM = CW'(NWIN - 2);

    logic [FIELD_W-1:0] field;

    assign need     = (save_q != LIM);
    assign is_other = (foreign_q != '0);
    assign field    = is_other ? cfg_q[2*FIELD_W-1:FIELD_W] : cfg_q[FIELD_W-1:0];
    assign offset   = {field, 2'b00};

endmodule

// File: rtl/rwo_ctrl.sv
module rwo_ctrl #(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN),
    localparam int WD = (CW > rwo_pkg::CFG_W) ? CW : rwo_pkg::CFG_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [1:0]                cmd_op,
    input  logic                      wr_en,
    input  logic [2:0]                wr_sel,
    input  logic [WD-1:0]             wr_data,
    output logic [CW-1:0]             save_room,
    output logic [CW-1:0]             restore_room,
    output logic [CW-1:0]             foreign_cnt,
    output logic [CW-1:0]             clean_cnt,
    output logic [rwo_pkg::CFG_W-1:0] spill_cfg,
    output logic                      trap_valid,
    output logic                      trap_other,
    output logic [rwo_pkg::OFS_W-1:0] trap_offset,
    output logic                      assert_err
);
    import rwo_pkg::*;

    localparam logic [CW-1:0] LIM = CW'(NWIN - 2);

    logic [CW-1:0]    save_q, restore_q, foreign_q, clean_q;
    logic [CFG_W-1:0] cfg_q;
    logic [CW-1:0]    save_n, restore_n, foreign_n, clean_n;
    logic             fail;
    logic             need, is_other;
    logic [OFS_W-1:0] offset;
    logic             other_q;
    logic [OFS_W-1:0] offset_q;
    logic             flush_hit;
    rwo_state_e       state_q, state_d;

    rwo_update #(.NWIN(NWIN), .CW(CW)) upd_i (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .save_q    (save_q),
        .restore_q (restore_q),
        .foreign_q (foreign_q),
        .clean_q   (clean_q),
        .save_n    (save_n),
        .restore_n (restore_n),
        .foreign_n (foreign_n),
        .clean_n   (clean_n),
        .fail      (fail)
    );

    rwo_flush #(.NWIN(NWIN), .CW(CW)) flu_i (
        .save_q    (save_q),
        .foreign_q (foreign_q),
        .cfg_q     (cfg_q),
        .need      (need),
        .is_other  (is_other),
        .offset    (offset)
    );

    assign flush_hit = cmd_valid && (cmd_op == OP_FLUSH_ALL) && need;

    // Counter and configuration registers; a direct write overrides the command result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_q    <= LIM;
            restore_q <= '0;
            foreign_q <= '0;
            clean_q   <= '0;
            cfg_q     <= '0;
        end else begin
            save_q    <= save_n;
            restore_q <= restore_n;
            foreign_q <= foreign_n;
            clean_q   <= clean_n;
            if (wr_en) begin
                case (wr_sel)
                    SEL_SAVE:    save_q    <= wr_data[CW-1:0];
                    SEL_RESTORE: restore_q <= wr_data[CW-1:0];
                    SEL_FOREIGN: foreign_q <= wr_data[CW-1:0];
                    SEL_CLEAN:   clean_q   <= wr_data[CW-1:0];
                    SEL_CFG:     cfg_q     <= wr_data[CFG_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Trap vector capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            other_q  <= 1'b0;
            offset_q <= '0;
        end else if (flush_hit) begin
            other_q  <= is_other;
            offset_q <= offset;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_TRAP, ST_FAULT: begin
                if (flush_hit) state_d = ST_TRAP;
                else if (fail) state_d = ST_FAULT;
                else           state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        trap_valid = 1'b0;
        assert_err = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_TRAP:  trap_valid = 1'b1;
            ST_FAULT: assert_err = 1'b1;
            default:  ;
        endcase
    end

    assign save_room    = save_q;
    assign restore_room = restore_q;
    assign foreign_cnt  = foreign_q;
    assign clean_cnt    = clean_q;
    assign spill_cfg    = cfg_q;
    assign trap_other   = other_q;
    assign trap_offset  = offset_q;

endmodule

// File: rtl/rwo_ctrl_chk.sv
module rwo_ctrl_chk #(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cmd_valid,
    input logic [1:0]                cmd_op,
    input logic                      wr_en,
    input logic [CW-1:0]             save_room,
    input logic [CW-1:0]             restore_room,
    input logic [CW-1:0]             foreign_cnt,
    input logic [CW-1:0]             clean_cnt,
    input logic                      trap_valid,
    input logic                      trap_other,
    input logic [rwo_pkg::OFS_W-1:0] trap_offset,
    input logic                      assert_err
);
    localparam logic [CW-1:0] LIM       = CW'(NWIN - 2);
    localparam logic [CW-1:0] CLEAN_MAX = CW'(NWIN - 1);

    logic spill_cmd, fill_cmd, flush_cmd;
    logic spill_good, fill_good;

    assign spill_cmd  = cmd_valid && (cmd_op == 2'b00) && !wr_en;
    assign fill_cmd   = cmd_valid && (cmd_op == 2'b01) && !wr_en;
    assign flush_cmd  = cmd_valid && (cmd_op == 2'b10);
    assign spill_good = (save_room < LIM) && ((foreign_cnt != '0) || (restore_room != '0));
    assign fill_good  = (restore_room < LIM) && ((save_room != '0) || (foreign_cnt != '0));

    AST_SPILL_SAVE_UP: assert property (@(posedge clk) disable iff (!rst_n)
        spill_cmd && spill_good |=> save_room == CW'($past(save_room) + CW'(1))); // R2

    AST_FILL_RESTORE_UP: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cmd && fill_good |=> restore_room == CW'($past(restore_room) + CW'(1))); // R3

    AST_CLEAN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cmd && fill_good && (clean_cnt == CLEAN_MAX) |=> $stable(clean_cnt)); // R4

    AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        spill_cmd && !spill_good |=> assert_err && $stable(save_room) && $stable(restore_room)
                                   && $stable(foreign_cnt) && $stable(clean_cnt)); // R5

    AST_FLUSH_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_cmd && (save_room != LIM) |=> trap_valid); // R6

    AST_NO_SPURIOUS_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_cmd && (save_room != LIM)) |=> !trap_valid); // R10

    AST_TRAP_KIND_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        flush_cmd && (save_room != LIM) && (foreign_cnt != '0) |=> trap_other); // R7

    AST_OFFSET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> trap_offset[1:0] == 2'b00); // R7

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_valid, assert_err})); // R10

endmodule

bind rwo_ctrl rwo_ctrl_chk #(.NWIN(NWIN)) chk_i (.*);

// File: tb/rwo_ctrl_tb_top.sv
`timescale 1ns/1ps
module rwo_ctrl_tb_top;

    localparam int NWIN = 8;
    localparam int CW   = $clog2(NWIN);
    localparam int WD   = (CW > 6) ? CW : 6;
    localparam int LIM  = NWIN - 2;
    localparam int CMAX = NWIN - 1;
    localparam int MASK = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = 3'd0;
    logic [WD-1:0] wr_data = '0;
    logic [CW-1:0] save_room, restore_room, foreign_cnt, clean_cnt;
    logic [5:0]    spill_cfg;
    logic          trap_valid, trap_other, assert_err;
    logic [4:0]    trap_offset;

    int n_cmp = 0;
    int n_bad = 0;
    int m_save, m_res, m_for, m_cln, m_cfg;

    always #2 clk = ~clk;

    rwo_ctrl #(.NWIN(NWIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .save_room(save_room), .restore_room(restore_room),
        .foreign_cnt(foreign_cnt), .clean_cnt(clean_cnt), .spill_cfg(spill_cfg),
        .trap_valid(trap_valid), .trap_other(trap_other),
        .trap_offset(trap_offset), .assert_err(assert_err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int field_ofs(input int cfg, input bit oth);
        return 4 * (oth ? ((cfg >> 3) & 7) : (cfg & 7));
    endfunction

    task automatic compare_all(input string tag, input bit e_trap, input bit e_oth,
                               input int e_ofs, input bit e_err);
        chk(tag, "save_room", int'(save_room), m_save);
        chk(tag, "restore_room", int'(restore_room), m_res);
        chk(tag, "foreign_cnt", int'(foreign_cnt), m_for);
        chk(tag, "clean_cnt", int'(clean_cnt), m_cln);
        chk(tag, "spill_cfg", int'(spill_cfg), m_cfg);
        chk(tag, "trap_valid", int'(trap_valid), int'(e_trap));
        chk(tag, "assert_err", int'(assert_err), int'(e_err));
        if (e_trap) begin
            chk(tag, "trap_other", int'(trap_other), int'(e_oth));
            chk(tag, "trap_offset", int'(trap_offset), e_ofs);
        end
    endtask

    // One cycle: drive at the falling edge, sample 1 ns after the rising edge.
    task automatic step(input bit v, input logic [1:0] op, input bit we,
                        input logic [2:0] sel, input int d, input string tag);
        int  e_save = m_save, e_res = m_res, e_for = m_for, e_cln = m_cln, e_cfg = m_cfg;
        bit  e_trap = 0, e_oth = 0, e_err = 0;
        int  e_ofs = 0;
        cmd_valid = v; cmd_op = op; wr_en = we; wr_sel = sel; wr_data = WD'(d);
        if (v) begin
            case (op)
                2'b00: if (m_save < LIM && (m_for != 0 || m_res != 0)) begin
                           e_save++;
                           if (m_for != 0) e_for--; else e_res--;
                       end else e_err = 1;
                2'b01: if (m_res < LIM && (m_save != 0 || m_for != 0)) begin
                           e_res++;
                           if (m_for != 0) e_for--; else e_save--;
                           if (m_cln < CMAX) e_cln++;
                       end else e_err = 1;
                2'b10: if (m_save != LIM) begin
                           e_trap = 1;
                           e_oth  = (m_for != 0);
                           e_ofs  = field_ofs(m_cfg, e_oth);
                       end
                default: ;
            endcase
        end
        if (we) begin
            case (sel)
                3'd0: e_save = d & MASK;
                3'd1: e_res  = d & MASK;
                3'd2: e_for  = d & MASK;
                3'd3: e_cln  = d & MASK;
                3'd4: e_cfg  = d & 63;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        m_save = e_save; m_res = e_res; m_for = e_for; m_cln = e_cln; m_cfg = e_cfg;
        compare_all(tag, e_trap, e_oth, e_ofs, e_err);
        cmd_valid = 1'b0; wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 2'b00, 1'b0, 3'd0, 0, tag);
    endtask

    task automatic wr(input logic [2:0] sel, input int d, input string tag);
        step(1'b0, 2'b00, 1'b1, sel, d, tag);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_save = LIM; m_res = 0; m_for = 0; m_cln = 0; m_cfg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        compare_all("R1", 1'b0, 1'b0, 0, 1'b0);
        // R6: nothing occupied, flush-all has no effect
        step(1'b1, 2'b10, 1'b0, 3'd0, 0, "R6");
        // R8: direct writes to each target
        wr(3'd0, 3, "R8");
        wr(3'd1, 2, "R8");
        wr(3'd2, 1, "R8");
        wr(3'd4, 6'b101_011, "R8");
        wr(3'd6, 5, "R8");
        // R7: other-context spill trap, offset from upper field
        step(1'b1, 2'b10, 1'b0, 3'd0, 0, "R7");
        idle("R10");
        // R2: spill-done drains foreign first, then restore
        step(1'b1, 2'b00, 1'b0, 3'd0, 0, "R2");
        step(1'b1, 2'b00, 1'b0, 3'd0, 0, "R2");
        // R3 and R4: fill-done with clean below its limit
        step(1'b1, 2'b01, 1'b0, 3'd0, 0, "R3");
        wr(3'd2, 1, "R3");
        step(1'b1, 2'b01, 1'b0, 3'd0, 0, "R3");
        wr(3'd3, CMAX, "R4");
        step(1'b1, 2'b01, 1'b0, 3'd0, 0, "R4");
        // R7: normal spill trap, offset from lower field
        step(1'b1, 2'b10, 1'b0, 3'd0, 0, "R7");
        // R5: precondition failures
        wr(3'd1, 0, "R5");
        wr(3'd2, 0, "R5");
        step(1'b1, 2'b00, 1'b0, 3'd0, 0, "R5");
        idle("R10");
        wr(3'd1, LIM, "R5");
        step(1'b1, 2'b01, 1'b0, 3'd0, 0, "R5");
        // R11: reserved opcode
        step(1'b1, 2'b11, 1'b0, 3'd0, 0, "R11");
        // R9: write collides with a command
        wr(3'd1, 2, "R9");
        wr(3'd0, 2, "R9");
        step(1'b1, 2'b00, 1'b1, 3'd0, 1, "R9");
        step(1'b1, 2'b01, 1'b1, 3'd3, 4, "R9");
        step(1'b1, 2'b10, 1'b1, 3'd0, LIM, "R9");
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            bit         v   = ($urandom % 4) != 0;
            logic [1:0] op  = 2'($urandom % 4);
            bit         we  = ($urandom % 5) == 0;
            logic [2:0] sel = 3'($urandom % 8);
            int         d   = int'($urandom % 64);
            string      tag;
            if (we && v)           tag = "R9";
            else if (!v)           tag = "R10";
            else if (op == 2'b00)  tag = "R2";
            else if (op == 2'b01)  tag = "R3";
            else if (op == 2'b10)  tag = "R6";
            else                   tag = "R11";
            step(v, op, we, sel, d, tag);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule